// File: doc/BRIEF.md
# Masked Packed Double-to-Half Conversion Unit

This unit takes a vector of two, four or eight 64-bit binary64 floating-point elements and turns each one into a 16-bit binary16 value. The results are packed from bit 0 upward in a 128-bit result bus. Every lane has its own converter. The lanes work in parallel, and a single register stage sits behind them, so each operation finishes one cycle after it starts.

Each lane has a write-mask bit. A lane that is not selected either keeps the matching 16-bit field of a separate old-destination input (merge mode) or is cleared (zero mode). A broadcast option makes every lane read element 0 of the source, but only when the source is flagged as coming from memory. The same control bit has a second use. When the source is a register and the width is 512 bits, it makes the unit take its rounding mode from a per-operation override field instead of the global rounding field. The exception flags of the selected lanes are ORed together and reported with the result.

Top module: `cvt_pd2ph_unit`

## Requirements
- R1: `vl_i` chooses the lane count: 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, and 2'b10 or 2'b11 gives 8 lanes. The result of lane j is placed in `dst_o[16j+15:16j]`.
- R2: A selected lane holds the binary16 rounding of its binary64 input. The 2-bit rounding code means: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. Subnormal binary16 results are produced and never flushed to zero.
- R3: A NaN input gives a quiet NaN that keeps the sign and the nine payload bits just below the quiet bit (result = sign, 5'h1F, 1, frac[50:42]). An infinity gives a signed infinity. A finite value too large for binary16 gives infinity under nearest-even, under toward-zero gives 0x7BFF with its sign, and under the two directed modes gives infinity only when rounding away from zero, otherwise 0x7BFF with its sign.
- R4: Lane j is converted when `mask_en_i` is 0 or `kmask_i[j]` is 1.
- R5: An unselected lane inside the active width is 0 when `zero_mode_i` is 1. When `zero_mode_i` is 0 it keeps `dst_i[16j+15:16j]`.
- R6: When `src_mem_i` and `bcast_rc_i` are both 1, every lane converts `src_i[63:0]`. Otherwise lane j converts `src_i[64j+63:64j]`.
- R7: The rounding code comes from `emb_rc_i` only when `src_mem_i` is 0, `vl_i` selects 8 lanes and `bcast_rc_i` is 1. In every other case it comes from `glob_rc_i`.
- R8: The result bits above the active width are 0: `dst_o[127:32]` for 2 lanes, `dst_o[127:64]` for 4 lanes.
- R9: `flags_o` bits are: 0 invalid (signaling NaN input), 1 denormal (binary64 subnormal input), 2 overflow, 3 underflow, 4 inexact. Each bit is the OR over the selected lanes only. Unselected lanes contribute nothing.
- R10: Underflow is set when the exact input magnitude is below 2^-14 and nonzero and the result is inexact. An overflow also sets inexact.
- R11: `done_o` is high exactly in the cycle after a cycle with `start_i` high, and `dst_o`/`flags_o` hold that operation's result until the next one completes. After reset `done_o`, `dst_o` and `flags_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation start; all other inputs sampled with it |
| vl_i | input | 2 | Vector width code |
| src_i | input | 512 | Eight binary64 source elements, element j at bits 64j+63:64j |
| src_mem_i | input | 1 | Source comes from memory |
| bcast_rc_i | input | 1 | Broadcast (memory source) or rounding override enable (register source) |
| emb_rc_i | input | 2 | Per-operation rounding code |
| glob_rc_i | input | 2 | Global rounding code |
| mask_en_i | input | 1 | Write mask in use |
| kmask_i | input | 8 | Per-lane mask bits |
| zero_mode_i | input | 1 | 1: clear unselected lanes, 0: merge |
| dst_i | input | 128 | Old destination value used for merging |
| done_o | output | 1 | Result valid |
| dst_o | output | 128 | Packed binary16 results |
| flags_o | output | 5 | ORed exception flags |

## Verification
The hardest cases to reach from the ports are values next to the edges of binary16: exact halfway points between subnormal steps, the value just past the largest finite number, and binary64 subnormals. Random binary64 values almost never land on them. The bench therefore feeds hand-picked encodings for these points through all four rounding codes, and it mixes in random values whose exponents cluster around the binary16 range. The dual meaning of `bcast_rc_i` also needs care. The same source vector is sent with the bit set as a register operand at full width, as a memory operand, and at a smaller width, and the override rounding code is chosen so that it gives a visibly different result from the global code.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int F64_W  = 64;
  localparam int F16_W  = 16;
  localparam int FLAG_W = 5;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  // bit 0 is inv, bit 4 is prec
  typedef struct packed {
    logic prec;
    logic unfl;
    logic ovfl;
    logic dnrm;
    logic inv;
  } cvt_flags_t;
endpackage

// File: rtl/cvt_f64_f16.sv
module cvt_f64_f16
  import cvt_pkg::*;
(
  input  logic [F64_W-1:0] src_i,
  input  rmode_e           rm_i,
  output logic [F16_W-1:0] res_o,
  output cvt_flags_t       flg_o
);
  localparam int SIG_W  = 53;
  localparam int PAD_W  = 64;
  localparam int WIDE_W = SIG_W + PAD_W;
  localparam int KEEP_W = 11;

  logic              sgn;
  logic [10:0]       bexp;
  logic [51:0]       frac;
  logic [SIG_W-1:0]  sig;
  logic signed [12:0] uexp;
  logic signed [12:0] below;
  logic [6:0]        shamt;
  logic [WIDE_W-1:0] wide;
  logic [KEEP_W-1:0] kept;
  logic [KEEP_W:0]   rounded;
  logic [4:0]        efld;
  logic [15:0]       mag;
  logic [14:0]       sat;
  logic              rbit, sbit, inc, tiny, big, is_nan, is_inf, is_zero, ovf, to_inf;
  logic [WIDE_W-1:KEEP_W+PAD_W] wide_unused;

  always_comb begin
    sgn     = src_i[63];
    bexp    = src_i[62:52];
    frac    = src_i[51:0];
    is_nan  = (bexp == 11'h7FF) && (frac != '0);
    is_inf  = (bexp == 11'h7FF) && (frac == '0);
    is_zero = (bexp == '0) && (frac == '0);
    sig     = {bexp != '0, frac};
    uexp    = (bexp == '0) ? -13'sd1022 : ($signed({2'b00, bexp}) - 13'sd1023);
    tiny    = uexp < -13'sd14;
    big     = uexp > 13'sd15;
    below   = -13'sd14 - uexp;
    if (!tiny)                 shamt = 7'd42;
    else if (below > 13'sd22)  shamt = 7'd64;
    else                       shamt = 7'(below + 13'sd42);
    wide        = {sig, {PAD_W{1'b0}}} >> shamt;
    kept        = wide[KEEP_W+PAD_W-1:PAD_W];
    wide_unused = wide[WIDE_W-1:KEEP_W+PAD_W];
    rbit        = wide[PAD_W-1];
    sbit        = |wide[PAD_W-2:0];
    unique case (rm_i)
      RM_NEAR: inc = rbit & (sbit | kept[0]);
      RM_DOWN: inc = sgn & (rbit | sbit);
      RM_UP:   inc = ~sgn & (rbit | sbit);
      default: inc = 1'b0;
    endcase
    rounded = {1'b0, kept} + {{KEEP_W{1'b0}}, inc};
    efld    = tiny ? 5'd0 : 5'(uexp + 13'sd14);
    mag     = {1'b0, efld, 10'd0} + {4'd0, rounded};
    ovf     = big || (mag >= 16'h7C00);
    to_inf  = (rm_i == RM_NEAR) || ((rm_i == RM_UP) && !sgn) || ((rm_i == RM_DOWN) && sgn);
    sat     = to_inf ? 15'h7C00 : 15'h7BFF;

    flg_o      = '0;
    flg_o.dnrm = (bexp == '0) && (frac != '0);
    if (is_nan) begin
      res_o     = {sgn, 5'h1F, 1'b1, frac[50:42]};
      flg_o.inv = ~frac[51];
    end else if (is_inf) begin
      res_o = {sgn, 15'h7C00};
    end else if (is_zero) begin
      res_o = {sgn, 15'd0};
    end else if (ovf) begin
      res_o      = {sgn, sat};
      flg_o.ovfl = 1'b1;
      flg_o.prec = 1'b1;
    end else begin
      res_o      = {sgn, mag[14:0]};
      flg_o.prec = rbit | sbit;
      flg_o.unfl = tiny & (rbit | sbit);
    end
  end
endmodule

// File: rtl/cvt_lane_ctrl.sv
module cvt_lane_ctrl
  import cvt_pkg::*;
#(
  parameter int MAX_LANES = 8
) (
  input  logic [1:0]           vl_i,
  input  logic                 src_mem_i,
  input  logic                 bcast_rc_i,
  input  logic [1:0]           emb_rc_i,
  input  logic [1:0]           glob_rc_i,
  input  logic                 mask_en_i,
  input  logic [MAX_LANES-1:0] kmask_i,
  output logic [MAX_LANES-1:0] act_o,
  output logic [MAX_LANES-1:0] sel_o,
  output logic                 bcast_o,
  output rmode_e               rm_o
);
  localparam int MIN_LANES = 2;
  localparam int MID_LANES = 2 * MIN_LANES;

  logic full_w;
  int   n_act;

  always_comb begin
    full_w  = vl_i[1];
    n_act   = full_w ? MAX_LANES : (vl_i[0] ? MID_LANES : MIN_LANES);
    bcast_o = src_mem_i & bcast_rc_i;
    rm_o    = (!src_mem_i && full_w && bcast_rc_i) ? rmode_e'(emb_rc_i) : rmode_e'(glob_rc_i);
    for (int j = 0; j < MAX_LANES; j++) begin
      act_o[j] = (j < n_act);
      sel_o[j] = act_o[j] & (~mask_en_i | kmask_i[j]);
    end
  end
endmodule

// File: rtl/cvt_flag_or.sv
module cvt_flag_or
  import cvt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]       sel_i,
  input  cvt_flags_t [N-1:0] flg_i,
  output cvt_flags_t         flg_o
);
  always_comb begin
    flg_o = '0;
    for (int j = 0; j < N; j++) begin
      if (sel_i[j]) flg_o = flg_o | flg_i[j];
    end
  end
endmodule

// File: rtl/cvt_pd2ph_unit.sv
module cvt_pd2ph_unit
  import cvt_pkg::*;
#(
  parameter int MAX_LANES = 8,
  localparam int SRC_W = MAX_LANES * F64_W,
  localparam int DST_W = MAX_LANES * F16_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        vl_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              src_mem_i,
  input  logic              bcast_rc_i,
  input  logic [1:0]        emb_rc_i,
  input  logic [1:0]        glob_rc_i,
  input  logic              mask_en_i,
  input  logic [MAX_LANES-1:0] kmask_i,
  input  logic              zero_mode_i,
  input  logic [DST_W-1:0]  dst_i,
  output logic              done_o,
  output logic [DST_W-1:0]  dst_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [MAX_LANES-1:0]     act, sel;
  logic                     bcast;
  rmode_e                   rm;
  cvt_flags_t [MAX_LANES-1:0] lane_flg;
  cvt_flags_t               flg_nxt;
  logic [DST_W-1:0]         dst_nxt;
  logic [DST_W-1:0]         dst_q;
  cvt_flags_t               flg_q;
  logic                     done_q;

  cvt_lane_ctrl #(.MAX_LANES(MAX_LANES)) u_ctrl (
    .vl_i       (vl_i),
    .src_mem_i  (src_mem_i),
    .bcast_rc_i (bcast_rc_i),
    .emb_rc_i   (emb_rc_i),
    .glob_rc_i  (glob_rc_i),
    .mask_en_i  (mask_en_i),
    .kmask_i    (kmask_i),
    .act_o      (act),
    .sel_o      (sel),
    .bcast_o    (bcast),
    .rm_o       (rm)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [F64_W-1:0] lane_src;
    logic [F16_W-1:0] lane_res;

    assign lane_src = bcast ? src_i[F64_W-1:0] : src_i[j*F64_W +: F64_W];

    cvt_f64_f16 u_cvt (
      .src_i (lane_src),
      .rm_i  (rm),
      .res_o (lane_res),
      .flg_o (lane_flg[j])
    );

    always_comb begin
      if (sel[j])                    dst_nxt[j*F16_W +: F16_W] = lane_res;
      else if (act[j] && !zero_mode_i) dst_nxt[j*F16_W +: F16_W] = dst_i[j*F16_W +: F16_W];
      else                           dst_nxt[j*F16_W +: F16_W] = '0;
    end
  end

  cvt_flag_or #(.N(MAX_LANES)) u_flags (
    .sel_i (sel),
    .flg_i (lane_flg),
    .flg_o (flg_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      dst_q  <= '0;
      flg_q  <= '0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        dst_q <= dst_nxt;
        flg_q <= flg_nxt;
      end
    end
  end

  assign done_o  = done_q;
  assign dst_o   = dst_q;
  assign flags_o = flg_q;
endmodule

// File: rtl/cvt_pd2ph_chk.sv
module cvt_pd2ph_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [1:0]   vl_i,
  input logic         mask_en_i,
  input logic [7:0]   kmask_i,
  input logic         zero_mode_i,
  input logic [127:0] dst_i,
  input logic         done_o,
  input logic [127:0] dst_o,
  input logic [4:0]   flags_o
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o); // R11
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o); // R11
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(dst_o) && $stable(flags_o))); // R11
  AST_UPPER_CLEAR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && vl_i == 2'b00) |=> (dst_o[127:32] == '0)); // R8
  AST_UPPER_CLEAR_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && vl_i == 2'b01) |=> (dst_o[127:64] == '0)); // R8
  AST_LANE0_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mask_en_i && !kmask_i[0] && zero_mode_i) |=> (dst_o[15:0] == '0)); // R5
  AST_LANE0_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mask_en_i && !kmask_i[0] && !zero_mode_i) |=> (dst_o[15:0] == $past(dst_i[15:0]))); // R5
  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mask_en_i && kmask_i == '0) |=> (flags_o == '0)); // R9
endmodule

bind cvt_pd2ph_unit cvt_pd2ph_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .vl_i        (vl_i),
  .mask_en_i   (mask_en_i),
  .kmask_i     (kmask_i),
  .zero_mode_i (zero_mode_i),
  .dst_i       (dst_i),
  .done_o      (done_o),
  .dst_o       (dst_o),
  .flags_o     (flags_o)
);

// File: tb/test_cvt_pd2ph_unit.sv
module test_cvt_pd2ph_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   vl_i;
  logic [511:0] src_i;
  logic         src_mem_i, bcast_rc_i, mask_en_i, zero_mode_i;
  logic [1:0]   emb_rc_i, glob_rc_i;
  logic [7:0]   kmask_i;
  logic [127:0] dst_i;
  logic         done_o;
  logic [127:0] dst_o;
  logic [4:0]   flags_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [127:0] last_dst;
  logic [4:0]   last_flg;

  always #4ns clk = ~clk;

  cvt_pd2ph_unit i_cvt_pd2ph_unit (.*);

  localparam logic [63:0] ONE    = 64'h3FF0000000000000;
  localparam logic [63:0] MTWOH  = 64'hC004000000000000;
  localparam logic [63:0] MAXH   = 64'h40EFFC0000000000;
  localparam logic [63:0] PASTH  = 64'h40EFFE0000000000;
  localparam logic [63:0] P2M24  = 64'h3E70000000000000;
  localparam logic [63:0] P2M25  = 64'h3E60000000000000;
  localparam logic [63:0] P3M26  = 64'h3E68000000000000;
  localparam logic [63:0] TENTH  = 64'h3FB999999999999A;
  localparam logic [63:0] PI     = 64'h400921FB54442D18;
  localparam logic [63:0] HUGE   = 64'h7E37E43C8800759C;
  localparam logic [63:0] MBIG   = 64'hC202A05F20000000;
  localparam logic [63:0] SNAN   = 64'h7FF0000000000001;
  localparam logic [63:0] QNAN   = 64'hFFF8A00000000000;
  localparam logic [63:0] PINF   = 64'h7FF0000000000000;
  localparam logic [63:0] MINF   = 64'hFFF0000000000000;
  localparam logic [63:0] DSUB   = 64'h0000000000000001;
  localparam logic [63:0] MZERO  = 64'h8000000000000000;
  localparam logic [63:0] NEGSML = 64'hBE68000000000000;

  // Scalar reference: bitwise shift-out with guard and sticky
  function automatic logic [20:0] ref_cvt(input logic [63:0] x, input logic [1:0] rm);
    logic s; int e; logic [51:0] m; logic [52:0] sig; int ex; int n;
    logic [11:0] k; logic rb, st, up; int bias; logic [15:0] r; logic [4:0] f;
    s = x[63]; e = int'(x[62:52]); m = x[51:0]; f = '0;
    if (e == 2047) begin
      if (m == '0) r = {s, 15'h7C00};
      else begin r = {s, 5'h1F, 1'b1, m[50:42]}; f[0] = ~m[51]; end
      return {f, r};
    end
    if (e == 0 && m == '0) return {5'b0, s, 15'd0};
    if (e == 0) f[1] = 1'b1;
    sig = {e != 0, m};
    ex = ((e == 0) ? 1 : e) - 1023;
    n = 42 + ((ex < -14) ? (-14 - ex) : 0);
    if (n > 70) n = 70;
    rb = 1'b0; st = 1'b0;
    for (int i = 0; i < n; i++) begin st = st | rb; rb = sig[0]; sig = sig >> 1; end
    k = sig[11:0];
    case (rm)
      2'd0: up = rb & (st | k[0]);
      2'd1: up = s & (rb | st);
      2'd2: up = ~s & (rb | st);
      default: up = 1'b0;
    endcase
    k = k + {11'd0, up};
    if (rb | st) f[4] = 1'b1;
    if (ex < -14) begin
      if (rb | st) f[3] = 1'b1;
      r = (k == 12'd1024) ? {s, 15'h0400} : {s, 5'd0, k[9:0]};
    end else begin
      if (k == 12'd2048) begin bias = ex + 16; k = 12'd1024; end
      else bias = ex + 15;
      if (bias >= 31) begin
        f[2] = 1'b1; f[4] = 1'b1;
        r = {s, (rm == 2'd0 || (rm == 2'd2 && !s) || (rm == 2'd1 && s)) ? 15'h7C00 : 15'h7BFF};
      end else r = {s, 5'(bias), k[9:0]};
    end
    return {f, r};
  endfunction

  // Vector reference built from the requirements
  task automatic model(output logic [127:0] d, output logic [4:0] fl);
    int nl; logic [1:0] rm; logic [20:0] o; logic [63:0] x;
    nl = (vl_i == 2'b00) ? 2 : (vl_i == 2'b01) ? 4 : 8;
    rm = (!src_mem_i && vl_i[1] && bcast_rc_i) ? emb_rc_i : glob_rc_i;
    d = '0; fl = '0;
    for (int j = 0; j < 8; j++) begin
      if (j < nl) begin
        if (!mask_en_i || kmask_i[j]) begin
          x = (src_mem_i && bcast_rc_i) ? src_i[63:0] : src_i[j*64 +: 64];
          o = ref_cvt(x, rm);
          d[j*16 +: 16] = o[15:0];
          fl = fl | o[20:16];
        end else if (!zero_mode_i) d[j*16 +: 16] = dst_i[j*16 +: 16];
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [1:0] vl, input logic mem, input logic b, input logic [1:0] erc,
                         input logic [1:0] grc, input logic men, input logic [7:0] k, input logic z);
    vl_i = vl; src_mem_i = mem; bcast_rc_i = b; emb_rc_i = erc; glob_rc_i = grc;
    mask_en_i = men; kmask_i = k; zero_mode_i = z;
  endtask

  // drive at a falling edge, result checked at the following falling edge
  task automatic do_op(input string tag);
    logic [127:0] ed; logic [4:0] ef;
    model(ed, ef);
    start_i = 1'b1;
    @(negedge clk);
    chk(tag, "done", {127'd0, done_o}, 128'd1);
    chk(tag, "dst", dst_o, ed);
    chk(tag, "flags", {123'd0, flags_o}, {123'd0, ef});
    last_dst = ed; last_flg = ef;
    start_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R11", "idle done", {127'd0, done_o}, 128'd0);
      chk("R11", "held dst", dst_o, last_dst);
      chk("R11", "held flags", {123'd0, flags_o}, {123'd0, last_flg});
    end
  endtask

  function automatic logic [63:0] rnd64();
    logic [10:0] ex;
    if ($urandom % 4 == 0) return {$urandom, $urandom};
    ex = 11'(1023 + int'($urandom % 60) - 42);
    return {1'($urandom), ex, 20'($urandom), $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; src_i = '0; dst_i = '0;
    set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "reset done", {127'd0, done_o}, 128'd0);
    chk("R11", "reset dst", dst_o, 128'd0);
    chk("R11", "reset flags", {123'd0, flags_o}, 128'd0);
    last_dst = '0; last_flg = '0;

    // R2 ordinary values under every rounding code
    src_i = {PI, TENTH, MZERO, P2M24, MAXH, MTWOH, ONE, NEGSML};
    for (int rm = 0; rm < 4; rm++) begin
      set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'(rm), 1'b0, 8'h00, 1'b0);
      do_op("R2");
    end

    // R3 special values and overflow per rounding code
    src_i = {PASTH, HUGE, MBIG, SNAN, QNAN, PINF, MINF, {1'b1, PASTH[62:0]}};
    for (int rm = 0; rm < 4; rm++) begin
      set_ctl(2'b11, 1'b0, 1'b0, 2'd0, 2'(rm), 1'b0, 8'h00, 1'b0);
      do_op("R3");
    end

    // R10 subnormal edges, tininess and binary64 subnormal input
    src_i = {P2M25, P3M26, DSUB, {1'b1, DSUB[62:0]}, P2M24, NEGSML, 64'h3F0FFC0000000000, 64'h3F0FFE0000000000};
    for (int rm = 0; rm < 4; rm++) begin
      set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'(rm), 1'b0, 8'h00, 1'b0);
      do_op("R10");
    end

    // R1 and R8: narrower widths with a full old destination
    dst_i = {8{16'hFFFF}};
    src_i = {PI, PI, PI, PI, TENTH, MTWOH, P2M24, ONE};
    set_ctl(2'b00, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 8'hFF, 1'b0);
    do_op("R1");
    set_ctl(2'b01, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 8'hF0, 1'b0);
    do_op("R8");
    set_ctl(2'b00, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 8'h00, 1'b1);
    do_op("R8");
    idle(3);

    // R4 and R5: mask patterns, merge then zero
    dst_i = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    src_i = {ONE, MTWOH, MAXH, TENTH, PI, P2M24, MZERO, SNAN};
    set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 8'hA5, 1'b0);
    do_op("R4");
    set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 8'h5A, 1'b0);
    do_op("R5");
    set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 8'h3C, 1'b1);
    do_op("R5");
    set_ctl(2'b01, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 8'h00, 1'b0);
    do_op("R5");

    // R9: flags only from selected lanes
    src_i = {ONE, ONE, ONE, ONE, ONE, HUGE, DSUB, SNAN};
    set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 8'hF8, 1'b1);
    do_op("R9");
    set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 8'h00, 1'b0);
    do_op("R9");
    set_ctl(2'b10, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 8'h04, 1'b0);
    do_op("R9");

    // R6: broadcast from memory, and no broadcast for a register source
    src_i = {ONE, MTWOH, MAXH, TENTH, PI, P2M24, MZERO, P3M26};
    set_ctl(2'b10, 1'b1, 1'b1, 2'd2, 2'd0, 1'b0, 8'h00, 1'b0);
    do_op("R6");
    set_ctl(2'b01, 1'b1, 1'b1, 2'd0, 2'd1, 1'b1, 8'h0B, 1'b1);
    do_op("R6");
    set_ctl(2'b00, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 8'h00, 1'b0);
    do_op("R6");

    // R7: override only for full-width register source
    src_i = {8{P2M25}};
    set_ctl(2'b10, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 8'h00, 1'b0);
    do_op("R7");
    set_ctl(2'b11, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 8'h00, 1'b0);
    do_op("R7");
    set_ctl(2'b10, 1'b1, 1'b1, 2'd2, 2'd0, 1'b0, 8'h00, 1'b0);
    do_op("R7");
    set_ctl(2'b01, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0, 8'h00, 1'b0);
    do_op("R7");
    set_ctl(2'b10, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 8'h00, 1'b0);
    do_op("R7");
    idle(2);

    // R2: random operations, back to back with occasional idle gaps
    for (int t = 0; t < 400; t++) begin
      for (int j = 0; j < 8; j++) src_i[j*64 +: 64] = rnd64();
      dst_i = {$urandom, $urandom, $urandom, $urandom};
      set_ctl(2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
              1'($urandom), 8'($urandom), 1'($urandom));
      do_op("R2");
      if ($urandom % 5 == 0) idle(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule